// File: doc/BRIEF.md
# Column Command Decoder with Deferred Write Buffer

This block is the column side of a memory device's command front end. Each cycle it may receive a 23-bit column command packet and a 17-bit companion packet, both already deserialized. The command packet is framed by its start bit. The block compares the packet's device field with its own identifier and decodes the opcode into reads, writes, precharges and a power-mode change. The companion packet carries one of two things. It is either a pair of byte-mask fields that apply to a write sent earlier, or an extended command with its own device, bank and opcode fields.

Write data is not stored at once. It is held in a one-entry buffer together with its bank, column and byte masks. On a later accepted packet the buffer is retired into a behavioural sense-amp array. The only packet that does not retire it is a read addressed to this same device. A write retires the old contents of the buffer first and then loads the new write. A write with auto-precharge asks for the precharge of its bank in the cycle in which its own data is retired.

Two state machines carry the state. The power machine has the states PWR_STBY and PWR_ATTN. It moves from PWR_STBY to PWR_ATTN on `go_attn`. It moves from PWR_ATTN to PWR_STBY on a standby request from the command opcode or from the extended opcode. The buffer machine has the states WB_EMPTY and WB_HELD. It moves from WB_EMPTY to WB_HELD on a write. It moves from WB_HELD to WB_EMPTY on a retire that brings no new write. It stays in WB_HELD on a retire that comes with a write.

Top module: `colpkt_wbuf`

## Requirements
- R1: The command packet layout is: bit 22 start, bit 21 ignored, bits 20:16 device, bits 15:11 bank, bits 10:4 column, bits 3:0 opcode. A packet whose start bit is 0 produces no output and does not change the buffer.
- R2: After reset the block is in standby. Packets are accepted only in attention. A one-cycle `go_attn` pulse in standby moves the block to attention, which shows on `pwr_attn` in the next cycle.
- R3: An accepted packet whose device field equals `dev_id` and whose opcode low bits are 011 (read) or 111 (read with precharge) sets `rd_valid` in the next cycle, with that bank, column and the array contents. Such a packet never retires the buffer.
- R4: When the buffer is held, every other accepted packet retires it. This includes packets addressed to another device. A retire raises `retire_stb` for one cycle in the next cycle, with the buffered bank and column, and writes the enabled bytes into the array.
- R5: Opcode low bits 001 (write) or 101 (write with precharge) addressed to this device first retire any held entry and then load the new bank, column and `wr_data`. The new entry starts with all bytes enabled.
- R6: A companion packet with bit 16 set is a mask. Bits 7:0 enable data bytes 0..7 (bits 9j+8:9j) and bits 15:8 enable data bytes 8..15. A bit of 1 writes the byte. The mask applies only when it arrives exactly 8 cycles after the held write's packet, and it takes effect on a retire in that same cycle.
- R7: A write with precharge raises `pre_wb_valid` with its bank, `pre_wb_bank`, in the same cycle as the `retire_stb` of its data.
- R8: Opcode low bits 100 (precharge) or 111 to this device raise `pre_col_valid` with the packet's bank in the next cycle.
- R9: Opcode bit 3 set, on a packet to this device, moves the block to standby after that packet, and the lower-bit command still executes.
- R10: A companion packet with bit 16 clear is an extended command: bits 14:10 device, bits 9:5 bank, bits 4:0 opcode. It acts only when its device equals `dev_id` and opcode bit 0 is 0. Bit 4 requests `prex_valid` with that bank. Bits 3:2 = 10 give `cal_stb` and 11 give `cal_sample_stb`. Bit 1 moves the block to standby. The flags combine.
- R11: Reset clears every strobe, empties the buffer and selects standby.
- R12: Reserved opcodes (low bits 010 or 110) to this device start no read, write or precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 5 | This device's identifier |
| go_attn | input | 1 | Request to enter attention from standby |
| col_pkt | input | 23 | Column command packet |
| aux_pkt | input | 17 | Companion mask or extended packet |
| wr_data | input | 144 | Write data that accompanies a write packet |
| rd_valid | output | 1 | Read request issued |
| rd_bank | output | 5 | Bank of the read |
| rd_col | output | 7 | Column of the read |
| rd_data | output | 144 | Array contents at the read address |
| retire_stb | output | 1 | Buffer retired into the array |
| retire_bank | output | 5 | Bank of the retired entry |
| retire_col | output | 7 | Column of the retired entry |
| pre_col_valid | output | 1 | Precharge from the command opcode |
| pre_col_bank | output | 5 | Bank for that precharge |
| pre_wb_valid | output | 1 | Deferred precharge after a retired write with precharge |
| pre_wb_bank | output | 5 | Bank for the deferred precharge |
| prex_valid | output | 1 | Precharge from the extended opcode |
| prex_bank | output | 5 | Bank for the extended precharge |
| cal_stb | output | 1 | Calibrate request |
| cal_sample_stb | output | 1 | Calibrate-and-sample request |
| pwr_attn | output | 1 | High in attention, low in standby |

## Verification
A write with precharge that is still buffered has its bank precharge released only when it retires. So a later packet can make that deferred precharge coincide with a new precharge from the opcode and with the retire itself. The bench provokes this in two steps. It parks a write with precharge to one bank, then sends an opcode precharge to another bank. In the next cycle it expects `retire_stb`, `pre_wb_valid` and `pre_col_valid` together, each carrying its own bank. A second pairing is a mask packet that lands on the same packet that retires the entry. It is judged by reading the location back and checking that only the enabled bytes carry the new data.

// File: rtl/colpkt_pkg.sv
package colpkt_pkg;

    typedef enum logic {
        PWR_STBY = 1'b0,
        PWR_ATTN = 1'b1
    } pwr_state_t;

    typedef enum logic {
        WB_EMPTY = 1'b0,
        WB_HELD  = 1'b1
    } wb_state_t;

    typedef enum logic [2:0] {
        COP_NOP  = 3'b000,
        COP_WR   = 3'b001,
        COP_RSVA = 3'b010,
        COP_RD   = 3'b011,
        COP_PREC = 3'b100,
        COP_WRA  = 3'b101,
        COP_RSVB = 3'b110,
        COP_RDA  = 3'b111
    } cop_low_t;

    typedef struct packed {
        logic do_read;
        logic do_write;
        logic auto_pre;
        logic do_prec;
        logic to_stby;
        logic retire_ok;
    } col_cmd_t;

    typedef struct packed {
        logic mask_sel;
        logic prex;
        logic cal;
        logic cal_sample;
        logic relax;
    } aux_cmd_t;

endpackage

// File: rtl/colpkt_decode.sv
module colpkt_decode
    import colpkt_pkg::*;
#(
    parameter int DEV_W      = 5,
    parameter int BANK_W     = 5,
    parameter int COL_W      = 7,
    parameter int LANE_BYTES = 8,
    localparam int OP_W      = 4,
    localparam int XOP_W     = 5,
    localparam int PKT_W     = 2 + DEV_W + BANK_W + COL_W + OP_W,
    localparam int AUX_W     = 1 + 2 * LANE_BYTES
) (
    input  logic [PKT_W-1:0]        col_pkt,
    input  logic [AUX_W-1:0]        aux_pkt,
    input  logic [DEV_W-1:0]        dev_id,
    input  logic                    attn,
    output col_cmd_t                cmd,
    output aux_cmd_t                xcmd,
    output logic [BANK_W-1:0]       bank,
    output logic [COL_W-1:0]        col,
    output logic [BANK_W-1:0]       xbank,
    output logic [2*LANE_BYTES-1:0] mask
);

    logic             start;
    logic             unused_rsv;
    logic [DEV_W-1:0] dc;
    logic [DEV_W-1:0] dx;
    logic [OP_W-1:0]  cop;
    logic [XOP_W-1:0] xop;
    logic             m_bit;
    logic             accept;
    logic             own;
    logic             xown;
    logic             is_read;
    cop_low_t         low;

    assign start      = col_pkt[PKT_W-1];
    assign unused_rsv = col_pkt[PKT_W-2];
    assign dc         = col_pkt[OP_W+COL_W+BANK_W +: DEV_W];
    assign bank       = col_pkt[OP_W+COL_W +: BANK_W];
    assign col        = col_pkt[OP_W +: COL_W];
    assign cop        = col_pkt[OP_W-1:0];

    assign m_bit = aux_pkt[AUX_W-1];
    assign mask  = aux_pkt[2*LANE_BYTES-1:0];
    assign xop   = aux_pkt[XOP_W-1:0];
    assign xbank = aux_pkt[XOP_W +: BANK_W];
    assign dx    = aux_pkt[XOP_W+BANK_W +: DEV_W];

    always_comb begin
        accept  = start && attn;
        own     = accept && (dc == dev_id);
        low     = cop_low_t'(cop[2:0]);
        is_read = (low == COP_RD) || (low == COP_RDA);

        cmd = '0;
        unique case (low)
            COP_WR:   cmd.do_write = own;
            COP_WRA: begin
                cmd.do_write = own;
                cmd.auto_pre = own;
            end
            COP_RD:   cmd.do_read = own;
            COP_RDA: begin
                cmd.do_read = own;
                cmd.do_prec = own;
            end
            COP_PREC: cmd.do_prec = own;
            default: ;
        endcase
        cmd.to_stby   = own && cop[OP_W-1];
        cmd.retire_ok = accept && !(own && is_read);

        xown            = accept && !m_bit && (dx == dev_id) && !xop[0];
        xcmd.mask_sel   = accept && m_bit;
        xcmd.prex       = xown && xop[4];
        xcmd.cal        = xown && (xop[3:2] == 2'b10);
        xcmd.cal_sample = xown && (xop[3:2] == 2'b11);
        xcmd.relax      = xown && xop[1];
    end

endmodule

// File: rtl/colpkt_wbuf_ctl.sv
module colpkt_wbuf_ctl
    import colpkt_pkg::*;
#(
    parameter int BANK_W    = 5,
    parameter int COL_W     = 7,
    parameter int DATA_W    = 144,
    parameter int MASK_BITS = 16,
    parameter int MASK_LAG  = 8,
    localparam int AGE_W    = $clog2(MASK_LAG + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 retire_ok,
    input  logic                 do_write,
    input  logic                 auto_pre,
    input  logic                 mask_sel,
    input  logic [BANK_W-1:0]    new_bank,
    input  logic [COL_W-1:0]     new_col,
    input  logic [DATA_W-1:0]    new_data,
    input  logic [MASK_BITS-1:0] new_mask,
    output logic                 ret_en,
    output logic [BANK_W-1:0]    ret_bank,
    output logic [COL_W-1:0]     ret_col,
    output logic [DATA_W-1:0]    ret_data,
    output logic [MASK_BITS-1:0] ret_mask,
    output logic                 retire_stb,
    output logic [BANK_W-1:0]    retire_bank,
    output logic [COL_W-1:0]     retire_col,
    output logic                 pre_wb_valid
);

    localparam logic [AGE_W-1:0] AGE_HIT = AGE_W'(MASK_LAG);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MASK_LAG + 1);

    wb_state_t            st_q, st_d;
    logic [BANK_W-1:0]    bank_q;
    logic [COL_W-1:0]     col_q;
    logic [DATA_W-1:0]    data_q;
    logic [MASK_BITS-1:0] mask_q;
    logic                 pre_q;
    logic [AGE_W-1:0]     age_q;
    logic                 mask_hit;

    always_comb begin
        mask_hit = (st_q == WB_HELD) && mask_sel && (age_q == AGE_HIT);
        ret_en   = (st_q == WB_HELD) && retire_ok;
        st_d     = st_q;
        unique case (st_q)
            WB_EMPTY: if (do_write) st_d = WB_HELD;
            WB_HELD:  if (ret_en && !do_write) st_d = WB_EMPTY;
            default:  st_d = WB_EMPTY;
        endcase
    end

    assign ret_bank = bank_q;
    assign ret_col  = col_q;
    assign ret_data = data_q;
    assign ret_mask = mask_hit ? new_mask : mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WB_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            col_q  <= '0;
            data_q <= '0;
            mask_q <= '1;
            pre_q  <= 1'b0;
            age_q  <= '0;
        end else if (do_write) begin
            bank_q <= new_bank;
            col_q  <= new_col;
            data_q <= new_data;
            mask_q <= '1;
            pre_q  <= auto_pre;
            age_q  <= AGE_W'(1);
        end else begin
            if (mask_hit) mask_q <= new_mask;
            if ((st_q == WB_HELD) && (age_q != AGE_MAX)) age_q <= age_q + AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_stb   <= 1'b0;
            retire_bank  <= '0;
            retire_col   <= '0;
            pre_wb_valid <= 1'b0;
        end else begin
            retire_stb   <= ret_en;
            retire_bank  <= bank_q;
            retire_col   <= col_q;
            pre_wb_valid <= ret_en && pre_q;
        end
    end

    p_retire_from_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retire_stb |-> $past(st_q == WB_HELD));

    p_wra_pre_with_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wb_valid |-> retire_stb);

    p_write_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> (st_q == WB_HELD));

endmodule

// File: rtl/colpkt_sense_array.sv
module colpkt_sense_array #(
    parameter int BYTE_W   = 9,
    parameter int NBYTE    = 16,
    parameter int AW       = 8,
    localparam int DATA_W  = BYTE_W * NBYTE,
    localparam int NENT    = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NBYTE-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar j = 0; j < NBYTE; j++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [NENT];
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[j]) lane_mem[wr_addr] <= wr_data[j*BYTE_W +: BYTE_W];
            if (rd_en)             lane_q <= lane_mem[rd_addr];
        end

        assign rd_data[j*BYTE_W +: BYTE_W] = lane_q;
    end

    p_no_rw_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: rtl/colpkt_wbuf.sv
module colpkt_wbuf
    import colpkt_pkg::*;
#(
    parameter int DEV_W      = 5,
    parameter int BANK_W     = 5,
    parameter int COL_W      = 7,
    parameter int BYTE_W     = 9,
    parameter int LANE_BYTES = 8,
    parameter int MASK_LAG   = 8,
    parameter int SA_BANK_W  = 1,
    localparam int NBYTE     = 2 * LANE_BYTES,
    localparam int DATA_W    = BYTE_W * NBYTE,
    localparam int PKT_W     = 2 + DEV_W + BANK_W + COL_W + 4,
    localparam int AUX_W     = 1 + 2 * LANE_BYTES,
    localparam int SA_AW     = SA_BANK_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic              go_attn,
    input  logic [PKT_W-1:0]  col_pkt,
    input  logic [AUX_W-1:0]  aux_pkt,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank,
    output logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              retire_stb,
    output logic [BANK_W-1:0] retire_bank,
    output logic [COL_W-1:0]  retire_col,
    output logic              pre_col_valid,
    output logic [BANK_W-1:0] pre_col_bank,
    output logic              pre_wb_valid,
    output logic [BANK_W-1:0] pre_wb_bank,
    output logic              prex_valid,
    output logic [BANK_W-1:0] prex_bank,
    output logic              cal_stb,
    output logic              cal_sample_stb,
    output logic              pwr_attn
);

    pwr_state_t          pwr_q, pwr_d;
    col_cmd_t            cmd;
    aux_cmd_t            xcmd;
    logic [BANK_W-1:0]   bank;
    logic [COL_W-1:0]    col;
    logic [BANK_W-1:0]   xbank;
    logic [NBYTE-1:0]    mask;
    logic                ret_en;
    logic [BANK_W-1:0]   ret_bank;
    logic [COL_W-1:0]    ret_col;
    logic [DATA_W-1:0]   ret_data;
    logic [NBYTE-1:0]    ret_mask;
    logic                attn;

    assign attn = (pwr_q == PWR_ATTN);

    colpkt_decode #(
        .DEV_W(DEV_W), .BANK_W(BANK_W), .COL_W(COL_W), .LANE_BYTES(LANE_BYTES)
    ) u_decode (
        .col_pkt(col_pkt), .aux_pkt(aux_pkt), .dev_id(dev_id), .attn(attn),
        .cmd(cmd), .xcmd(xcmd), .bank(bank), .col(col), .xbank(xbank), .mask(mask)
    );

    colpkt_wbuf_ctl #(
        .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .MASK_BITS(NBYTE), .MASK_LAG(MASK_LAG)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .retire_ok(cmd.retire_ok), .do_write(cmd.do_write), .auto_pre(cmd.auto_pre),
        .mask_sel(xcmd.mask_sel),
        .new_bank(bank), .new_col(col), .new_data(wr_data), .new_mask(mask),
        .ret_en(ret_en), .ret_bank(ret_bank), .ret_col(ret_col),
        .ret_data(ret_data), .ret_mask(ret_mask),
        .retire_stb(retire_stb), .retire_bank(retire_bank), .retire_col(retire_col),
        .pre_wb_valid(pre_wb_valid)
    );

    assign pre_wb_bank = retire_bank;

    colpkt_sense_array #(
        .BYTE_W(BYTE_W), .NBYTE(NBYTE), .AW(SA_AW)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ret_en), .wr_addr({ret_bank[SA_BANK_W-1:0], ret_col}),
        .wr_be(ret_mask), .wr_data(ret_data),
        .rd_en(cmd.do_read), .rd_addr({bank[SA_BANK_W-1:0], col}),
        .rd_data(rd_data)
    );

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PWR_STBY: if (go_attn) pwr_d = PWR_ATTN;
            PWR_ATTN: if (cmd.to_stby || xcmd.relax) pwr_d = PWR_STBY;
            default:  pwr_d = PWR_STBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= PWR_STBY;
        else        pwr_q <= pwr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid       <= 1'b0;
            rd_bank        <= '0;
            rd_col         <= '0;
            pre_col_valid  <= 1'b0;
            pre_col_bank   <= '0;
            prex_valid     <= 1'b0;
            prex_bank      <= '0;
            cal_stb        <= 1'b0;
            cal_sample_stb <= 1'b0;
        end else begin
            rd_valid       <= cmd.do_read;
            rd_bank        <= bank;
            rd_col         <= col;
            pre_col_valid  <= cmd.do_prec;
            pre_col_bank   <= bank;
            prex_valid     <= xcmd.prex;
            prex_bank      <= xbank;
            cal_stb        <= xcmd.cal;
            cal_sample_stb <= xcmd.cal_sample;
        end
    end

    assign pwr_attn = attn;

    p_start_low_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !col_pkt[PKT_W-1] |=> !(rd_valid || retire_stb || pre_col_valid ||
                                prex_valid || cal_stb || cal_sample_stb));

    p_stby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_q == PWR_STBY) |=> !(rd_valid || retire_stb || pre_col_valid ||
                                  prex_valid || cal_stb || cal_sample_stb));

    p_own_read_no_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.do_read |=> !retire_stb);

    p_stby_after_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.to_stby || xcmd.relax) |=> !pwr_attn);

    p_cal_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_stb && cal_sample_stb));

endmodule

// File: tb/colpkt_wbuf_tb.sv
`timescale 1ns/1ps
module colpkt_wbuf_tb;

    localparam int DATA_W = 144;
    localparam int NV     = 16;
    localparam int VW     = 47;

    // each row: {command packet, companion packet, expected
    // {rd_valid, retire_stb, pre_col_valid, prex_valid, cal_stb, cal_sample_stb, pwr_attn}}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 1'b0, 5'd3, 5'd0, 7'd0, 4'h0, 17'd0, 7'b0000001},
        {1'b1, 1'b0, 5'd3, 5'd2, 7'd5, 4'h1, 17'd0, 7'b0000001},
        {1'b1, 1'b0, 5'd3, 5'd2, 7'd5, 4'h3, 17'd0, 7'b1000001},
        {1'b1, 1'b0, 5'd4, 5'd2, 7'd5, 4'h3, 17'd0, 7'b0100001},
        {1'b1, 1'b0, 5'd3, 5'd1, 7'd9, 4'h5, 17'd0, 7'b0000001},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 17'd0, 7'b0100001},
        {1'b1, 1'b0, 5'd3, 5'd7, 7'd0, 4'h4, 17'd0, 7'b0010001},
        {1'b1, 1'b0, 5'd3, 5'd7, 7'd3, 4'h7, 17'd0, 7'b1010001},
        {1'b1, 1'b0, 5'd3, 5'd0, 7'd0, 4'h2, 17'd0, 7'b0000001},
        {1'b0, 1'b0, 5'd3, 5'd2, 7'd5, 4'h1, 17'd0, 7'b0000001},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd6, 5'b10000, 7'b0001001},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd0, 5'b01000, 7'b0000101},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd0, 5'b01100, 7'b0000011},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd4, 5'd0, 5'b10000, 7'b0000001},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd0, 5'b00001, 7'b0000001},
        {1'b1, 1'b0, 5'd4, 5'd0, 7'd0, 4'h0, 1'b0, 1'b0, 5'd3, 5'd2, 5'b10010, 7'b0001000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        dev_id = 5'd3;
    logic              go_attn = 1'b0;
    logic [22:0]       col_pkt = '0;
    logic [16:0]       aux_pkt = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_valid, retire_stb, pre_col_valid, pre_wb_valid, prex_valid;
    logic              cal_stb, cal_sample_stb, pwr_attn;
    logic [4:0]        rd_bank, retire_bank, pre_col_bank, pre_wb_bank, prex_bank;
    logic [6:0]        rd_col, retire_col;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    colpkt_wbuf u_dut (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .go_attn(go_attn),
        .col_pkt(col_pkt), .aux_pkt(aux_pkt), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_col(rd_col), .rd_data(rd_data),
        .retire_stb(retire_stb), .retire_bank(retire_bank), .retire_col(retire_col),
        .pre_col_valid(pre_col_valid), .pre_col_bank(pre_col_bank),
        .pre_wb_valid(pre_wb_valid), .pre_wb_bank(pre_wb_bank),
        .prex_valid(prex_valid), .prex_bank(prex_bank),
        .cal_stb(cal_stb), .cal_sample_stb(cal_sample_stb), .pwr_attn(pwr_attn)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chkd(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input logic [8:0] seed);
        logic [DATA_W-1:0] v;
        for (int j = 0; j < 16; j++) v[j*9 +: 9] = seed + 9'(j * 37);
        return v;
    endfunction

    function automatic logic [22:0] mkc(input logic [4:0] dv, input logic [4:0] bk,
                                        input logic [6:0] cl, input logic [3:0] op);
        return {1'b1, 1'b0, dv, bk, cl, op};
    endfunction

    task automatic put(input logic [22:0] p, input logic [16:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        col_pkt = p;
        aux_pkt = a;
        wr_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        col_pkt = '0;
        aux_pkt = '0;
        wr_data = '0;
    endtask

    task automatic send(input logic [22:0] p, input logic [16:0] a, input logic [DATA_W-1:0] d);
        put(p, a, d);
        idle();
    endtask

    task automatic pulse_attn();
        @(negedge clk);
        go_attn = 1'b1;
        @(negedge clk);
        go_attn = 1'b0;
    endtask

    initial begin
        logic [DATA_W-1:0] d1, d2, d3, exp_m;
        d1 = pat(9'h011);
        d2 = pat(9'h0C3);
        d3 = pat(9'h155);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chkv("R11 reset pwr_attn", 32'(pwr_attn), 32'd0);
        chkv("R11 reset strobes", 32'({rd_valid, retire_stb, pre_col_valid, pre_wb_valid,
                                      prex_valid, cal_stb, cal_sample_stb}), 32'd0);

        send(mkc(5'd3, 5'd0, 7'd1, 4'h3), 17'd0, '0);
        chkv("R2 read in standby ignored", 32'(rd_valid), 32'd0);
        pulse_attn();
        chkv("R2 attention entered", 32'(pwr_attn), 32'd1);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][VW-1 -: 23], VEC[i][23:7], d1);
            chkv($sformatf("R1,R3,R4,R8,R9,R10,R12 vector %0d", i),
                 32'({rd_valid, retire_stb, pre_col_valid, prex_valid,
                      cal_stb, cal_sample_stb, pwr_attn}), 32'(VEC[i][6:0]));
            if (i == 10) chkv("R10 prex bank", 32'(prex_bank), 32'd6);
            if (i == 6)  chkv("R8 precharge bank", 32'(pre_col_bank), 32'd7);
            if (i == 2)  chkv("R3 read column", 32'(rd_col), 32'd5);
        end

        pulse_attn();
        send(mkc(5'd3, 5'd0, 7'd1, 4'h1), 17'd0, d1);
        send(mkc(5'd3, 5'd0, 7'd2, 4'h1), 17'd0, d2);
        chkv("R5 write retires old entry", 32'(retire_stb), 32'd1);
        chkv("R5 retired column", 32'(retire_col), 32'd1);
        send(mkc(5'd3, 5'd0, 7'd1, 4'h3), 17'd0, '0);
        chkv("R3 own read does not retire", 32'(retire_stb), 32'd0);
        chkd("R4 retired data read back", rd_data, d1);
        send(mkc(5'd9, 5'd0, 7'd0, 4'h0), 17'd0, '0);
        chkv("R4 other-device packet retires", 32'(retire_stb), 32'd1);
        chkv("R4 retired column", 32'(retire_col), 32'd2);
        send(mkc(5'd3, 5'd0, 7'd2, 4'h3), 17'd0, '0);
        chkd("R5 second write data", rd_data, d2);

        put(mkc(5'd3, 5'd0, 7'd1, 4'h1), 17'd0, d3);
        repeat (7) idle();
        put(mkc(5'd9, 5'd0, 7'd0, 4'h0), {1'b1, 8'h80, 8'h01}, '0);
        idle();
        chkv("R6 retire with mask", 32'(retire_stb), 32'd1);
        exp_m = d1;
        exp_m[8:0]     = d3[8:0];
        exp_m[143:135] = d3[143:135];
        send(mkc(5'd3, 5'd0, 7'd1, 4'h3), 17'd0, '0);
        chkd("R6 masked bytes", rd_data, exp_m);

        send(mkc(5'd3, 5'd6, 7'd3, 4'h5), 17'd0, d2);
        chkv("R7 no precharge while held", 32'(pre_wb_valid), 32'd0);
        send(mkc(5'd3, 5'd4, 7'd0, 4'h4), 17'd0, '0);
        chkv("R7 retire strobe", 32'(retire_stb), 32'd1);
        chkv("R7 deferred precharge", 32'(pre_wb_valid), 32'd1);
        chkv("R7 deferred bank", 32'(pre_wb_bank), 32'd6);
        chkv("R8 same-cycle precharge", 32'(pre_col_valid), 32'd1);
        chkv("R8 same-cycle bank", 32'(pre_col_bank), 32'd4);

        send(mkc(5'd3, 5'd0, 7'd1, 4'hB), 17'd0, '0);
        chkv("R9 read executes", 32'(rd_valid), 32'd1);
        chkv("R9 standby entered", 32'(pwr_attn), 32'd0);
        send(mkc(5'd3, 5'd0, 7'd1, 4'h3), 17'd0, '0);
        chkv("R9 packet after standby ignored", 32'(rd_valid), 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule